// File: doc/BRIEF.md
# RGMII Gigabit Frame Transmitter

This block turns a byte stream from a valid/ready source into an Ethernet frame on a 4-bit RGMII-style transmit bus with a control line. It runs on a single clock at the nibble rate, which is twice the 125 MHz transmit clock. Each clock cycle stands for one edge of that transmit clock. A level output, `tx_clk_hi`, marks which half of the byte slot is on the bus. The DDR output cells, clock generation and the 90-degree skew are left to the pad ring that follows.

For every frame the block sends seven preamble bytes and a start delimiter. It then sends the payload, pads short payloads with zeros, and appends the Ethernet CRC-32 frame check sequence that it computes as the bytes go out. After the frame it holds the line idle for a programmable number of byte times. The source must present the payload bytes without gaps once the frame has started; the block pulls one byte per byte slot through `s_ready`.

Top module: `rgmii_frame_tx`

## Requirements
- R1: While reset is held and in the first cycles after it, `txd` is 0, `tx_ctl` is low and `s_ready` is low.
- R2: Whenever `tx_ctl` is low, `txd` is 0.
- R3: A frame starts with seven 0x55 bytes and then the delimiter byte 0xD5. `tx_ctl` rises in a cycle where `tx_clk_hi` is 1, and the first nibble it carries is 0x5.
- R4: `tx_clk_hi` toggles every cycle. Each byte takes two consecutive cycles: bits [3:0] go out with `tx_clk_hi`=1, then bits [7:4] go out with `tx_clk_hi`=0.
- R5: The payload bytes follow the delimiter in the order they were accepted.
- R6: A payload shorter than MIN_PAYLOAD (60) bytes is followed by zero bytes, so that exactly MIN_PAYLOAD bytes come before the check sequence.
- R7: The check sequence is a CRC-32 with reflected polynomial 0xEDB88320 and seed 0xFFFFFFFF, taken over payload and padding. It is complemented and sent least significant byte first. The CRC register run over payload, padding and check sequence therefore ends at 0xDEBB20E3.
- R8: `tx_ctl` falls right after the last check-sequence nibble. A frame of L payload bytes holds `tx_ctl` high for 2*(8+max(L,60)+4) cycles, and the last high cycle has `tx_clk_hi`=0.
- R9: When the next frame is already waiting, `tx_ctl` stays low for exactly 2*max(`ifg_bytes`,1) cycles between frames.
- R10: `s_ready` is high only while `tx_ctl` is high, only in cycles where `tx_clk_hi` is 0, and never in two cycles in a row. Exactly one handshake takes place per payload byte.
- R11: While `s_valid` is low and no frame is in progress, no frame starts and `tx_ctl` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble-rate clock (twice the transmit clock) |
| rst_n | input | 1 | Synchronous active-low reset |
| s_data | input | 8 | Payload byte from the source |
| s_valid | input | 1 | Source byte valid |
| s_last | input | 1 | Marks the final payload byte of a frame |
| s_ready | output | 1 | Byte taken at this clock edge when high with `s_valid` |
| ifg_bytes | input | IFG_W (8) | Idle gap between frames in byte times |
| txd | output | 4 | Transmit nibble |
| tx_ctl | output | 1 | Transmit enable, high for the whole frame |
| tx_clk_hi | output | 1 | Modelled transmit clock level; 1 on the first half of a byte |

## Verification
The bench builds the block with its defaults: seven preamble bytes, a minimum payload of 60 and an 8-bit gap field. With these values, payloads of 1, 4, 10 and 20 bytes exercise padding, while payloads of 60, 61, 64 and 70 bytes run through the boundary where padding stops. The gap input is driven at 0, 1, 3 and 12 for back-to-back frames, which covers the floor of one byte time and the normal twelve-byte gap. The check sequence is checked two ways: against the bench's own computed bytes, and through the fixed residue over the received frame.

// File: rtl/rgmii_tx_pkg.sv
// Shared types and helpers for the RGMII frame transmitter.
// Holds the frame state encoding, the fixed framing bytes and a byte-wide
// reflected CRC-32 update. Assumes data enters the CRC least significant bit first.
package rgmii_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_DATA,
        ST_PAD,
        ST_FCS,
        ST_GAP
    } tx_state_e;

    localparam logic [7:0]  PREAMBLE_BYTE = 8'h55;
    localparam logic [7:0]  DELIM_BYTE    = 8'hD5;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;
    localparam int          FCS_BYTES     = 4;

    // Advance a reflected CRC-32 register by one byte, LSB first.
    function automatic logic [31:0] crc32_step(input logic [31:0] cur, input logic [7:0] din);
        logic [31:0] r;
        r = cur;
        for (int i = 0; i < 8; i++) begin
            r = (r >> 1) ^ (((r[0] ^ din[i]) == 1'b1) ? CRC_POLY_REFL : 32'h0);
        end
        return r;
    endfunction

endpackage

// File: rtl/rgmii_crc32.sv
// Running CRC-32 register for the frame check sequence.
// Assumes one byte update per enable and a reseed pulse before each frame;
// reseed wins over enable. crc_nxt is the value after absorbing din.
module rgmii_crc32
    import rgmii_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reseed,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_nxt
);

    logic [31:0] crc_q;

    // Combinational next value for the byte now on the bus.
    always_comb begin
        crc_nxt = crc32_step(crc_q, din);
    end

    // Hold the running remainder between byte slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (reseed) begin
            crc_q <= CRC_SEED;
        end else if (en) begin
            crc_q <= crc_nxt;
        end
    end

endmodule

// File: rtl/rgmii_gap_timer.sv
// Counts byte times of idle between frames.
// start loads the count with one (first gap byte under way); tick marks the end
// of each gap byte. done is high once the count has reached the programmed
// length, so a length of zero behaves as one byte time.
module rgmii_gap_timer #(
    parameter int IFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  logic [IFG_W-1:0] ifg_len,
    output logic             done
);

    logic [IFG_W-1:0] gcnt_q;

    // Gap is over once the count has caught up with the programmed length.
    always_comb begin
        done = (gcnt_q >= ifg_len);
    end

    // Load on gap entry, advance once per finished gap byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcnt_q <= '0;
        end else if (start) begin
            gcnt_q <= IFG_W'(1);
        end else if (tick && !done) begin
            gcnt_q <= gcnt_q + IFG_W'(1);
        end
    end

endmodule

// File: rtl/rgmii_tx_fsm.sv
// Byte-level frame sequencer.
// All decisions happen at the end of a byte slot (ph high). byte_q holds the
// byte now being serialised. Assumes the source keeps s_valid high for every
// payload byte once a frame has started; s_ready pulses once per byte slot.
module rgmii_tx_fsm
    import rgmii_tx_pkg::*;
#(
    parameter int PRE_BYTES   = 7,
    parameter int MIN_PAYLOAD = 60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ph,
    input  logic        s_valid,
    input  logic [7:0]  s_data,
    input  logic        s_last,
    input  logic [31:0] crc_nxt,
    input  logic        gap_done,
    output tx_state_e   state,
    output logic [7:0]  byte_q,
    output logic        s_ready,
    output logic        crc_reseed,
    output logic        crc_en,
    output logic        gap_start,
    output logic        gap_tick
);

    localparam int CNT_MAX = (MIN_PAYLOAD > PRE_BYTES) ? MIN_PAYLOAD : PRE_BYTES;
    localparam int CNT_W   = $clog2(CNT_MAX + FCS_BYTES + 1);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_BYTES - 1);
    localparam logic [CNT_W-1:0] PAY_LAST = CNT_W'(MIN_PAYLOAD - 1);
    localparam logic [CNT_W-1:0] FCS_LAST = CNT_W'(FCS_BYTES - 1);

    tx_state_e        st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last_q;
    logic [31:0]      fcs_q;

    assign state = st_q;

    // Strobes to the source, CRC and gap timer, all at byte boundaries.
    always_comb begin
        s_ready    = ph && ((st_q == ST_SFD) || ((st_q == ST_DATA) && !last_q));
        crc_reseed = ph && (st_q == ST_SFD);
        crc_en     = ph && ((st_q == ST_DATA) || (st_q == ST_PAD));
        gap_start  = ph && (st_q == ST_FCS) && (cnt_q == FCS_LAST);
        gap_tick   = ph && (st_q == ST_GAP);
    end

    // Frame sequencing: preamble, delimiter, payload, padding, FCS, gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            byte_q <= '0;
            last_q <= 1'b0;
            fcs_q  <= '0;
        end else if (ph) begin
            case (st_q)
                ST_IDLE: begin
                    if (s_valid) begin
                        st_q   <= ST_PRE;
                        byte_q <= PREAMBLE_BYTE;
                        cnt_q  <= '0;
                    end
                end
                ST_PRE: begin
                    if (cnt_q == PRE_LAST) begin
                        st_q   <= ST_SFD;
                        byte_q <= DELIM_BYTE;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_SFD: begin
                    st_q   <= ST_DATA;
                    byte_q <= s_data;
                    last_q <= s_last;
                    cnt_q  <= '0;
                end
                ST_DATA: begin
                    if (last_q) begin
                        if (cnt_q < PAY_LAST) begin
                            st_q   <= ST_PAD;
                            byte_q <= 8'h00;
                            cnt_q  <= cnt_q + CNT_W'(1);
                        end else begin
                            st_q   <= ST_FCS;
                            fcs_q  <= ~crc_nxt;
                            byte_q <= ~crc_nxt[7:0];
                            cnt_q  <= '0;
                        end
                    end else begin
                        byte_q <= s_data;
                        last_q <= s_last;
                        if (cnt_q < PAY_LAST) begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_PAD: begin
                    if (cnt_q == PAY_LAST) begin
                        st_q   <= ST_FCS;
                        fcs_q  <= ~crc_nxt;
                        byte_q <= ~crc_nxt[7:0];
                        cnt_q  <= '0;
                    end else begin
                        byte_q <= 8'h00;
                        cnt_q  <= cnt_q + CNT_W'(1);
                    end
                end
                ST_FCS: begin
                    if (cnt_q == FCS_LAST) begin
                        st_q   <= ST_GAP;
                        byte_q <= 8'h00;
                        last_q <= 1'b0;
                    end else begin
                        byte_q <= fcs_q[15:8];
                        fcs_q  <= fcs_q >> 8;
                        cnt_q  <= cnt_q + CNT_W'(1);
                    end
                end
                ST_GAP: begin
                    if (gap_done) begin
                        if (s_valid) begin
                            st_q   <= ST_PRE;
                            byte_q <= PREAMBLE_BYTE;
                            cnt_q  <= '0;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rgmii_frame_tx.sv
// RGMII gigabit frame transmitter, nibble-rate model.
// One clk cycle per transmit-clock edge: the low nibble of each byte goes out
// while tx_clk_hi is 1, the high nibble while it is 0. Assumes clk runs at
// twice the transmit clock and that DDR output cells follow this block.
module rgmii_frame_tx
    import rgmii_tx_pkg::*;
#(
    parameter int PRE_BYTES   = 7,
    parameter int MIN_PAYLOAD = 60,
    parameter int IFG_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       s_data,
    input  logic             s_valid,
    input  logic             s_last,
    output logic             s_ready,
    input  logic [IFG_W-1:0] ifg_bytes,
    output logic [3:0]       txd,
    output logic             tx_ctl,
    output logic             tx_clk_hi
);

    logic        ph_q;
    tx_state_e   state;
    logic [7:0]  cur_byte;
    logic [31:0] crc_nxt;
    logic        crc_reseed;
    logic        crc_en;
    logic        gap_start;
    logic        gap_tick;
    logic        gap_done;
    logic        active;

    // Half-slot phase: 0 = first nibble, 1 = second nibble of a byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= 1'b0;
        end else begin
            ph_q <= ~ph_q;
        end
    end

    rgmii_tx_fsm #(
        .PRE_BYTES  (PRE_BYTES),
        .MIN_PAYLOAD(MIN_PAYLOAD)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph        (ph_q),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_last    (s_last),
        .crc_nxt   (crc_nxt),
        .gap_done  (gap_done),
        .state     (state),
        .byte_q    (cur_byte),
        .s_ready   (s_ready),
        .crc_reseed(crc_reseed),
        .crc_en    (crc_en),
        .gap_start (gap_start),
        .gap_tick  (gap_tick)
    );

    rgmii_crc32 i_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .reseed (crc_reseed),
        .en     (crc_en),
        .din    (cur_byte),
        .crc_nxt(crc_nxt)
    );

    rgmii_gap_timer #(
        .IFG_W(IFG_W)
    ) i_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (gap_start),
        .tick   (gap_tick),
        .ifg_len(ifg_bytes),
        .done   (gap_done)
    );

    // Bus drive: nibble select by phase, zero and control low outside a frame.
    always_comb begin
        active    = (state != ST_IDLE) && (state != ST_GAP);
        tx_ctl    = active;
        tx_clk_hi = ~ph_q;
        if (active) begin
            txd = ph_q ? cur_byte[7:4] : cur_byte[3:0];
        end else begin
            txd = 4'h0;
        end
    end

endmodule

// File: rtl/rgmii_tx_checker.sv
// Port-level protocol checks for rgmii_frame_tx, attached by bind.
// Assumes the synchronous active-low reset of the checked block.
module rgmii_tx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       s_ready,
    input logic [3:0] txd,
    input logic       tx_ctl,
    input logic       tx_clk_hi
);

    // R2: the bus is quiet outside a frame.
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ctl |-> (txd == 4'h0));

    // R3: a frame opens on the first half of a byte with a preamble nibble.
    p_frame_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ctl) |-> (tx_clk_hi && (txd == 4'h5)));

    // R8: a frame closes after a second-half nibble.
    p_frame_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_ctl) |-> !$past(tx_clk_hi));

    // R10: bytes are pulled only inside a frame, on the second half.
    p_ready_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (tx_ctl && !tx_clk_hi));

    // R10: at most one pull per byte slot.
    p_ready_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);

endmodule

bind rgmii_frame_tx rgmii_tx_checker i_rgmii_tx_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_ready  (s_ready),
    .txd      (txd),
    .tx_ctl   (tx_ctl),
    .tx_clk_hi(tx_clk_hi)
);

// File: tb/test_rgmii_frame_tx.sv
`timescale 1ns/1ps
module test_rgmii_frame_tx;

    localparam int MINP = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_valid = 1'b0;
    logic       s_last = 1'b0;
    logic       s_ready;
    logic [7:0] ifg_bytes = 8'd12;
    logic [3:0] txd;
    logic       tx_ctl;
    logic       tx_clk_hi;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [4:0] exp_q[$];
    int         len_q[$];
    int         gap_q[$];

    always #2.5 clk = ~clk;

    rgmii_frame_tx i_rgmii_frame_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_data   (s_data),
        .s_valid  (s_valid),
        .s_last   (s_last),
        .s_ready  (s_ready),
        .ifg_bytes(ifg_bytes),
        .txd      (txd),
        .tx_ctl   (tx_ctl),
        .tx_clk_hi(tx_clk_hi)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        logic fb;
        r = c;
        for (int k = 0; k < 8; k++) begin
            fb = r[0] ^ b[k];
            r  = {1'b0, r[31:1]};
            if (fb) r = r ^ 32'hEDB88320;
        end
        return r;
    endfunction

    task automatic push_byte(input logic [7:0] b);
        exp_q.push_back({1'b1, b[3:0]});
        exp_q.push_back({1'b0, b[7:4]});
    endtask

    // Driver: queue the expected frame, then hand the payload to the block.
    task automatic send_frame(input int len, input int seed, input bit b2b);
        logic [7:0]  pay[$];
        logic [31:0] c;
        int          tot;
        int          hs;
        tot = (len < MINP) ? MINP : len;
        for (int i = 0; i < len; i++) pay.push_back(8'((seed + i * 29) ^ (i << 3)));
        len_q.push_back(len);
        gap_q.push_back(b2b ? 2 * ((ifg_bytes == 0) ? 1 : int'(ifg_bytes)) : -1);
        for (int i = 0; i < 7; i++) push_byte(8'h55);
        push_byte(8'hD5);
        c = 32'hFFFFFFFF;
        for (int i = 0; i < tot; i++) begin
            logic [7:0] b;
            b = (i < len) ? pay[i] : 8'h00;
            push_byte(b);
            c = ref_crc(c, b);
        end
        c = ~c;
        for (int i = 0; i < 4; i++) push_byte(c[8*i +: 8]);
        hs = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            s_valid = 1'b1;
            s_data  = pay[i];
            s_last  = (i == len - 1);
            while (!s_ready) @(negedge clk);
            @(posedge clk);
            hs++;
        end
        check(hs == len, "R10 handshakes", hs, len);
    endtask

    task automatic drop_valid();
        @(negedge clk);
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    // Monitor: pop expected nibbles and check framing, gap and residue.
    bit         prev_ctl = 1'b0;
    int         low_run = 0;
    int         nib_cnt = 0;
    int         cur_len = 0;
    logic [3:0] lo_nib = 4'h0;
    logic [7:0] rx_bytes[$];

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_ctl) begin
                if (!prev_ctl) begin
                    int eg;
                    eg = (gap_q.size() != 0) ? gap_q.pop_front() : -1;
                    if (eg >= 0) check(low_run == eg, "R9 gap cycles", low_run, eg);
                    cur_len = (len_q.size() != 0) ? len_q.pop_front() : 0;
                    nib_cnt = 0;
                    rx_bytes.delete();
                end
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 nibble beyond frame", txd, 0);
                end else begin
                    logic [4:0] e;
                    int bi;
                    int tot;
                    string tag;
                    e   = exp_q.pop_front();
                    bi  = nib_cnt / 2;
                    tot = (cur_len < MINP) ? MINP : cur_len;
                    if (bi < 8) tag = "R3 preamble/R4";
                    else if (bi < 8 + cur_len) tag = "R5 payload/R4";
                    else if (bi < 8 + tot) tag = "R6 padding/R4";
                    else tag = "R7 fcs/R4";
                    check({tx_clk_hi, txd} == e, tag, {tx_clk_hi, txd}, e);
                end
                if (tx_clk_hi) lo_nib = txd;
                else rx_bytes.push_back({txd, lo_nib});
                nib_cnt++;
                low_run = 0;
            end else begin
                if (prev_ctl) begin
                    int tot;
                    logic [31:0] r;
                    tot = (cur_len < MINP) ? MINP : cur_len;
                    check(nib_cnt == 2 * (8 + tot + 4), "R8 frame length", nib_cnt, 2 * (8 + tot + 4));
                    r = 32'hFFFFFFFF;
                    for (int i = 8; i < rx_bytes.size(); i++) r = ref_crc(r, rx_bytes[i]);
                    check(r == 32'hDEBB20E3, "R7 residue", r, 32'hDEBB20E3);
                end
                check(txd == 4'h0, "R2 idle bus", txd, 0);
                check(!s_ready, "R10 ready outside frame", s_ready, 0);
                low_run++;
            end
            prev_ctl = tx_ctl;
        end
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int ctl_hits;
        int tog_bad;
        logic prev_c;
        repeat (3) @(negedge clk);
        check(txd == 4'h0 && !tx_ctl && !s_ready, "R1 in reset", {tx_ctl, s_ready, txd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd == 4'h0 && !tx_ctl && !s_ready, "R1 after reset", {tx_ctl, s_ready, txd}, 0);

        // R11: no frame without valid; R4: clock level toggles.
        ctl_hits = 0;
        tog_bad  = 0;
        prev_c   = tx_clk_hi;
        repeat (40) begin
            @(negedge clk);
            if (tx_ctl) ctl_hits++;
            if (tx_clk_hi == prev_c) tog_bad++;
            prev_c = tx_clk_hi;
        end
        check(ctl_hits == 0, "R11 idle without valid", ctl_hits, 0);
        check(tog_bad == 0, "R4 clock toggle", tog_bad, 0);

        ifg_bytes = 8'd12;
        send_frame(4, 8'h12, 1'b0);  drop_valid(); drain();
        send_frame(1, 8'hA5, 1'b0);  drop_valid(); drain();
        send_frame(60, 8'h3C, 1'b0); drop_valid(); drain();
        send_frame(61, 8'h81, 1'b0); drop_valid(); drain();
        send_frame(64, 8'hF0, 1'b0); drop_valid(); drain();

        ifg_bytes = 8'd3;
        send_frame(10, 8'h01, 1'b0);
        send_frame(70, 8'h77, 1'b1);
        send_frame(5, 8'hE4, 1'b1);  drop_valid(); drain();

        ifg_bytes = 8'd0;
        send_frame(20, 8'h5A, 1'b0);
        send_frame(20, 8'hC3, 1'b1); drop_valid(); drain();

        ifg_bytes = 8'd1;
        send_frame(8, 8'h99, 1'b0);
        send_frame(8, 8'h66, 1'b1);  drop_valid(); drain();

        ifg_bytes = 8'd12;
        send_frame(64, 8'h2B, 1'b0);
        send_frame(64, 8'hD2, 1'b1); drop_valid(); drain();

        check(exp_q.size() == 0, "R8 all nibbles sent", exp_q.size(), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule